// File: doc/BRIEF.md
# DMA Register and Interrupt Unit

This block is the software-visible register file of a multi-channel DMA controller, built for either 2 or 8 channels. Each channel holds five 32-bit words: source address, destination address, link pointer, control and configuration. The block also holds a global configuration word and a sync word. The transfer engine is a separate block. It reads these registers, and it reports finished or failed transfers by pulsing per-channel set inputs.

Each channel's configuration word also gates that channel's interrupts. One bit masks the terminal-count source and another masks the error source, so there is no separate mask register. Raw and masked status can both be read. Status bits are cleared by writing ones to them. Three interrupt lines come from the masked status: error, terminal count, and their OR. A small window of read-only identification bytes tells software which channel count the hardware has.

The bus is a single-cycle port addressed by byte offset; bits [1:0] are ignored. A write takes effect at the clock edge on which `wr_en` is high. Read data is a combinational function of `addr` and the register state.

Top module: `dmac_regfile`

## Requirements
- R1: A channel word sits at byte offset 0x100 + 0x20*channel + 4*index. The index values are 0 source, 1 destination, 2 link pointer, 3 control and 4 configuration. Each word stores a full 32-bit write and reads it back.
- R2: The global configuration word at offset 0x030 and the sync word at offset 0x034 store a full 32-bit write and read it back.
- R3: For channel i, status bit i is masked by configuration bit 15 (terminal count) and by bit 14 (error). Masked terminal-count status reads at 0x004, masked error status at 0x00C, and their bitwise OR at 0x000. Bit i of each read belongs to channel i and the upper bits read 0.
- R4: A high `tc_set[i]` or `err_set[i]` at a clock edge sets the matching raw bit at that edge. Raw terminal-count status reads at 0x014 and raw error status at 0x018.
- R5: A write to 0x008 clears each raw terminal-count bit whose data bit is 1. A write to 0x010 does the same for raw error bits. When a set pulse and a clear hit the same bit in one cycle, the bit ends up set.
- R6: `irq_tc` is high exactly when the masked terminal-count status is non-zero, and `irq_err` is high exactly when the masked error status is non-zero. `irq_any` is their OR.
- R7: Offset 0x01C reads a bitmap whose bit i is bit 0 of channel i's configuration word.
- R8: Offsets 0xFE0 to 0xFFC each return one identification byte in bits [7:0], with the upper bits 0. In order the bytes are 0x81 for the 2-channel build or 0x80 for the 8-channel build, then 0x10, 0x04, 0x0A, 0x0D, 0xF0, 0x05, 0xB1.
- R9: Some addresses are undefined: a channel index at or above the channel count, a channel word index of 5 to 7, or a global offset with no register. Reads of these return 0 and writes to them change no register.
- R10: Offsets 0x020 to 0x02C accept writes and change nothing, and reads of them return 0.
- R11: Reset clears every register and status bit, so all reads and all interrupt outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for this cycle |
| addr | input | 12 | Byte offset of the access; bits [1:0] are ignored |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr` |
| tc_set | input | NUM_CH | Terminal-count set pulses from the transfer engine |
| err_set | input | NUM_CH | Error set pulses from the transfer engine |
| irq_err | output | 1 | Masked error interrupt |
| irq_tc | output | 1 | Masked terminal-count interrupt |
| irq_any | output | 1 | OR of the two interrupts |

## Verification
Read data is combinational, so a wrong stored word or status bit shows on `rdata` as soon as software reads that address. Nothing delays or filters the value. A bad mask bit or raw bit also shows on the interrupt lines in the cycle after the edge that stored it, with no read needed. The bench checks the interrupt lines on every read. A decode error that lets a write to an undefined address touch a real register stays hidden until that register is read. For that reason the random phase keeps reading back the valid channel and global words.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
   localparam int REG_ADDR_W   = 12;
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_ERRM_BIT = 14;
   localparam int CFG_TCM_BIT  = 15;
   localparam int CHAN_WORDS   = 5;

   typedef enum logic [2:0] {
      CR_SRC  = 3'd0,
      CR_DST  = 3'd1,
      CR_LINK = 3'd2,
      CR_CTRL = 3'd3,
      CR_CFG  = 3'd4
   } chan_reg_e;

   // global word indices (addr[7:2] inside the low page)
   localparam logic [5:0] GW_STAT_ALL = 6'd0;
   localparam logic [5:0] GW_STAT_TC  = 6'd1;
   localparam logic [5:0] GW_CLR_TC   = 6'd2;
   localparam logic [5:0] GW_STAT_ERR = 6'd3;
   localparam logic [5:0] GW_CLR_ERR  = 6'd4;
   localparam logic [5:0] GW_RAW_TC   = 6'd5;
   localparam logic [5:0] GW_RAW_ERR  = 6'd6;
   localparam logic [5:0] GW_EN_MAP   = 6'd7;
   localparam logic [5:0] GW_GCFG     = 6'd12;
   localparam logic [5:0] GW_SYNC     = 6'd13;

   function automatic logic [7:0] ident_byte(input logic [2:0] idx, input int nch);
      case (idx)
         3'd0:    ident_byte = (nch == 8) ? 8'h80 : 8'h81;
         3'd1:    ident_byte = 8'h10;
         3'd2:    ident_byte = 8'h04;
         3'd3:    ident_byte = 8'h0A;
         3'd4:    ident_byte = 8'h0D;
         3'd5:    ident_byte = 8'hF0;
         3'd6:    ident_byte = 8'h05;
         default: ident_byte = 8'hB1;
      endcase
   endfunction
endpackage

// File: rtl/dmac_chan_bank.sv
module dmac_chan_bank
   import dmac_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        reg_sel,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              cfg_en,
   output logic              cfg_tc_mask,
   output logic              cfg_err_mask
);
   logic [DATA_W-1:0] words [CHAN_WORDS];

   for (genvar w = 0; w < CHAN_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               words[w] <= '0;
         else if (wr_en && reg_sel == 3'(w))       words[w] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int w = 0; w < CHAN_WORDS; w++)
         if (reg_sel == 3'(w)) rdata = words[w];
   end

   assign cfg_en       = words[CR_CFG][CFG_EN_BIT];
   assign cfg_tc_mask  = words[CR_CFG][CFG_TCM_BIT];
   assign cfg_err_mask = words[CR_CFG][CFG_ERRM_BIT];
endmodule

// File: rtl/dmac_irq_status.sv
module dmac_irq_status #(
   parameter int NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] tc_set,
   input  logic [NUM_CH-1:0] err_set,
   input  logic              tc_clr,
   input  logic              err_clr,
   input  logic [NUM_CH-1:0] clr_val,
   input  logic [NUM_CH-1:0] tc_mask,
   input  logic [NUM_CH-1:0] err_mask,
   output logic [NUM_CH-1:0] tc_raw,
   output logic [NUM_CH-1:0] err_raw,
   output logic [NUM_CH-1:0] tc_masked,
   output logic [NUM_CH-1:0] err_masked,
   output logic              irq_tc,
   output logic              irq_err
);
   logic [NUM_CH-1:0] tc_drop, err_drop;
   assign tc_drop  = tc_clr  ? clr_val : '0;
   assign err_drop = err_clr ? clr_val : '0;

   // set pulse is ORed in after the clear, so it wins on a collision
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tc_raw  <= '0;
         err_raw <= '0;
      end else begin
         tc_raw  <= (tc_raw  & ~tc_drop)  | tc_set;
         err_raw <= (err_raw & ~err_drop) | err_set;
      end
   end

   assign tc_masked  = tc_raw  & tc_mask;
   assign err_masked = err_raw & err_mask;
   assign irq_tc     = |tc_masked;
   assign irq_err    = |err_masked;
endmodule

// File: rtl/dmac_id_rom.sv
module dmac_id_rom
   import dmac_pkg::*;
#(
   parameter int NUM_CH = 2
) (
   input  logic [2:0] idx,
   output logic [7:0] id_byte
);
   assign id_byte = ident_byte(idx, NUM_CH);
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
   import dmac_pkg::*;
#(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [REG_ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [DATA_W-1:0]     rdata,
   input  logic [NUM_CH-1:0]     tc_set,
   input  logic [NUM_CH-1:0]     err_set,
   output logic                  irq_err,
   output logic                  irq_tc,
   output logic                  irq_any
);
   localparam int PAD_W = DATA_W - NUM_CH;

   if (!(NUM_CH == 2 || NUM_CH == 8)) begin : g_bad_nch
      $error("dmac_regfile: NUM_CH must be 2 or 8");
   end
   if (DATA_W < 16) begin : g_bad_dw
      $error("dmac_regfile: DATA_W must hold the mask bits");
   end

   // address decode
   logic       unused_lsb;
   logic       in_glob, in_chan, in_id, ch_valid, reg_valid;
   logic [2:0] sel_ch, sel_reg;
   logic [5:0] gidx;

   assign unused_lsb = ^addr[1:0];
   assign in_glob    = addr[11:8] == 4'h0;
   assign in_chan    = addr[11:8] == 4'h1;
   assign in_id      = addr[11:5] == 7'h7F;
   assign sel_ch     = addr[7:5];
   assign sel_reg    = addr[4:2];
   assign gidx       = addr[7:2];
   assign ch_valid   = {1'b0, sel_ch} < 4'(NUM_CH);
   assign reg_valid  = sel_reg < 3'(CHAN_WORDS);

   // channel banks
   logic [DATA_W-1:0] chan_rd [NUM_CH];
   logic [NUM_CH-1:0] en_map, tc_mask, err_mask;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dmac_chan_bank #(.DATA_W(DATA_W)) u_bank (
         .clk          (clk),
         .rst_n        (rst_n),
         .wr_en        (wr_en && in_chan && reg_valid && sel_ch == 3'(c)),
         .reg_sel      (sel_reg),
         .wdata        (wdata),
         .rdata        (chan_rd[c]),
         .cfg_en       (en_map[c]),
         .cfg_tc_mask  (tc_mask[c]),
         .cfg_err_mask (err_mask[c])
      );
   end

   // global words
   logic [DATA_W-1:0] gcfg_q, sync_q;
   logic              glob_wr;
   assign glob_wr = wr_en && in_glob;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gcfg_q <= '0;
         sync_q <= '0;
      end else begin
         if (glob_wr && gidx == GW_GCFG) gcfg_q <= wdata;
         if (glob_wr && gidx == GW_SYNC) sync_q <= wdata;
      end
   end

   // interrupt status
   logic [NUM_CH-1:0] tc_raw, err_raw, tc_masked, err_masked;

   dmac_irq_status #(.NUM_CH(NUM_CH)) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .tc_set     (tc_set),
      .err_set    (err_set),
      .tc_clr     (glob_wr && gidx == GW_CLR_TC),
      .err_clr    (glob_wr && gidx == GW_CLR_ERR),
      .clr_val    (wdata[NUM_CH-1:0]),
      .tc_mask    (tc_mask),
      .err_mask   (err_mask),
      .tc_raw     (tc_raw),
      .err_raw    (err_raw),
      .tc_masked  (tc_masked),
      .err_masked (err_masked),
      .irq_tc     (irq_tc),
      .irq_err    (irq_err)
   );
   assign irq_any = irq_tc | irq_err;

   // identification bytes
   logic [7:0] id_byte;
   dmac_id_rom #(.NUM_CH(NUM_CH)) u_id (
      .idx     (sel_reg),
      .id_byte (id_byte)
   );

   // read mux
   function automatic logic [DATA_W-1:0] zext(input logic [NUM_CH-1:0] v);
      return {{PAD_W{1'b0}}, v};
   endfunction

   logic [DATA_W-1:0] ch_rd;
   always_comb begin
      ch_rd = '0;
      for (int c = 0; c < NUM_CH; c++)
         if (sel_ch == 3'(c)) ch_rd = chan_rd[c];
   end

   always_comb begin
      rdata = '0;
      if (in_id) begin
         rdata = {{(DATA_W-8){1'b0}}, id_byte};
      end else if (in_chan) begin
         if (ch_valid && reg_valid) rdata = ch_rd;
      end else if (in_glob) begin
         case (gidx)
            GW_STAT_ALL: rdata = zext(tc_masked | err_masked);
            GW_STAT_TC:  rdata = zext(tc_masked);
            GW_STAT_ERR: rdata = zext(err_masked);
            GW_RAW_TC:   rdata = zext(tc_raw);
            GW_RAW_ERR:  rdata = zext(err_raw);
            GW_EN_MAP:   rdata = zext(en_map);
            GW_GCFG:     rdata = gcfg_q;
            GW_SYNC:     rdata = sync_q;
            default:     rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk #(
   parameter int NUM_CH = 2,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [11:0]       addr,
   input logic [DATA_W-1:0] wdata,
   input logic [NUM_CH-1:0] tc_set,
   input logic [NUM_CH-1:0] err_set,
   input logic [NUM_CH-1:0] tc_raw,
   input logic [NUM_CH-1:0] err_raw,
   input logic              irq_err,
   input logic              irq_tc,
   input logic              irq_any
);
   AST_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |=> (tc_raw == '0 && err_raw == '0 && !irq_any)); // R11

   AST_TC_SET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (|tc_set) |=> ((tc_raw & $past(tc_set)) == $past(tc_set))); // R4

   AST_ERR_SET_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (|err_set) |=> ((err_raw & $past(err_set)) == $past(err_set))); // R4

   AST_TC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[11:8] == 4'h0 && addr[7:2] == 6'd2)
      |=> ((tc_raw & $past(wdata[NUM_CH-1:0] & ~tc_set)) == '0)); // R5

   AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr[11:8] == 4'h0 && addr[7:2] == 6'd4)
      |=> ((err_raw & $past(wdata[NUM_CH-1:0] & ~err_set)) == '0)); // R5

   AST_TC_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_tc |-> (tc_raw != '0)); // R6

   AST_ERR_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_err |-> (err_raw != '0)); // R6
endmodule

bind dmac_regfile dmac_regfile_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .tc_set  (tc_set),
   .err_set (err_set),
   .tc_raw  (tc_raw),
   .err_raw (err_raw),
   .irq_err (irq_err),
   .irq_tc  (irq_tc),
   .irq_any (irq_any)
);

// File: tb/dmac_regfile_bench.sv
module dmac_regfile_bench;
   localparam int NC = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NC-1:0] tc_set = '0, err_set = '0;
   logic        irq_err, irq_tc, irq_any;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   dmac_regfile u_dmac_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .tc_set(tc_set), .err_set(err_set),
      .irq_err(irq_err), .irq_tc(irq_tc), .irq_any(irq_any)
   );

   // reference model
   logic [31:0]   m_ch [NC][5];
   logic [31:0]   m_gcfg, m_sync;
   logic [NC-1:0] m_tc, m_err;

   task automatic model_reset();
      for (int c = 0; c < NC; c++) for (int r = 0; r < 5; r++) m_ch[c][r] = '0;
      m_gcfg = '0; m_sync = '0; m_tc = '0; m_err = '0;
   endtask

   function automatic logic [NC-1:0] tcm();
      for (int c = 0; c < NC; c++) tcm[c] = m_ch[c][4][15];
   endfunction
   function automatic logic [NC-1:0] erm();
      for (int c = 0; c < NC; c++) erm[c] = m_ch[c][4][14];
   endfunction
   function automatic logic [NC-1:0] enm();
      for (int c = 0; c < NC; c++) enm[c] = m_ch[c][4][0];
   endfunction

   function automatic logic [7:0] id_exp(input int i);
      case (i)
         0: return 8'h81; 1: return 8'h10; 2: return 8'h04; 3: return 8'h0A;
         4: return 8'h0D; 5: return 8'hF0; 6: return 8'h05; default: return 8'hB1;
      endcase
   endfunction

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      int c = int'(a[7:5]);
      int r = int'(a[4:2]);
      if (a[11:5] == 7'h7F) return {24'h0, id_exp(r)};
      if (a[11:8] == 4'h1) begin
         if (c < NC && r < 5) return m_ch[c][r];
         return '0;
      end
      if (a[11:8] != 4'h0) return '0;
      case (int'(a[7:2]))
         0:  return 32'((m_tc & tcm()) | (m_err & erm()));
         1:  return 32'(m_tc & tcm());
         3:  return 32'(m_err & erm());
         5:  return 32'(m_tc);
         6:  return 32'(m_err);
         7:  return 32'(enm());
         12: return m_gcfg;
         13: return m_sync;
         default: return '0;
      endcase
   endfunction

   function automatic string tag_of(input logic [11:0] a);
      int c = int'(a[7:5]);
      int r = int'(a[4:2]);
      if (a[11:5] == 7'h7F) return "R8";
      if (a[11:8] == 4'h1) return (c < NC && r < 5) ? "R1" : "R9";
      if (a[11:8] != 4'h0) return "R9";
      case (int'(a[7:2]))
         0, 1, 3:    return "R3";
         5, 6:       return "R4";
         7:          return "R7";
         8, 9, 10, 11: return "R10";
         12, 13:     return "R2";
         default:    return "R9";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   // one bus cycle with optional write and set pulses
   task automatic step(input bit we, input logic [11:0] a, input logic [31:0] d,
                       input logic [NC-1:0] ts, input logic [NC-1:0] es);
      int c = int'(a[7:5]);
      int r = int'(a[4:2]);
      @(negedge clk);
      wr_en = we; addr = a; wdata = d; tc_set = ts; err_set = es;
      @(posedge clk);
      #1;
      if (we) begin
         if (a[11:8] == 4'h1) begin
            if (c < NC && r < 5) m_ch[c][r] = d;
         end else if (a[11:8] == 4'h0) begin
            case (int'(a[7:2]))
               2:  m_tc  = m_tc  & ~d[NC-1:0];
               4:  m_err = m_err & ~d[NC-1:0];
               12: m_gcfg = d;
               13: m_sync = d;
               default: ;
            endcase
         end
      end
      m_tc  = m_tc  | ts;
      m_err = m_err | es;
      wr_en = 1'b0; tc_set = '0; err_set = '0;
   endtask

   task automatic rd(input logic [11:0] a);
      logic et, ee;
      @(negedge clk);
      addr = a;
      #1;
      check(tag_of(a), rdata, exp_read(a));
      et = |(m_tc & tcm());
      ee = |(m_err & erm());
      check("R6", {29'h0, irq_any, irq_tc, irq_err}, {29'h0, et | ee, et, ee});
   endtask

   function automatic logic [11:0] rand_addr();
      case ($urandom_range(0, 3))
         0: return 12'h100 | 12'($urandom_range(0, 63) << 2);
         1: return 12'($urandom_range(0, 15) << 2);
         2: return 12'hFE0 | 12'($urandom_range(0, 7) << 2);
         default: return 12'($urandom) & 12'hFFC;
      endcase
   endfunction

   function automatic logic [NC-1:0] rand_pulse();
      return ($urandom_range(0, 3) == 0) ? NC'($urandom) : '0;
   endfunction

   initial begin
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11: reset state
      rd(12'h000); rd(12'h014); rd(12'h018); rd(12'h030); rd(12'h110); rd(12'h130);

      // R8: identification bytes
      for (int i = 0; i < 8; i++) rd(12'hFE0 + 12'(4 * i));

      // R1 / R7: fill channel words
      for (int c = 0; c < NC; c++)
         for (int r = 0; r < 5; r++) begin
            step(1'b1, 12'(12'h100 + 32 * c + 4 * r), $urandom, '0, '0);
            rd(12'(12'h100 + 32 * c + 4 * r));
         end
      step(1'b1, 12'h110, 32'h0000_C001, '0, '0); // ch0: both masks + enable
      step(1'b1, 12'h130, 32'h0000_0000, '0, '0); // ch1: no masks
      rd(12'h01C);

      // R2: global words
      step(1'b1, 12'h030, 32'hA5A5_0F0F, '0, '0); rd(12'h030);
      step(1'b1, 12'h034, 32'h1234_5678, '0, '0); rd(12'h034);

      // R4 / R3 / R6: set pulses, masked vs raw
      step(1'b0, 12'h000, '0, 2'b11, 2'b10);
      rd(12'h014); rd(12'h018); rd(12'h004); rd(12'h00C); rd(12'h000);

      // R5: clear with simultaneous set, set wins
      step(1'b1, 12'h008, 32'h3, 2'b01, '0);
      rd(12'h014);
      step(1'b1, 12'h010, 32'hFFFF_FFFF, '0, '0);
      rd(12'h018); rd(12'h000);

      // R9: out-of-range channel and word index writes ignored
      step(1'b1, 12'h150, 32'hDEAD_BEEF, '0, '0); rd(12'h150);
      step(1'b1, 12'h1F0, 32'hDEAD_BEEF, '0, '0); rd(12'h1F0);
      step(1'b1, 12'h114, 32'hDEAD_BEEF, '0, '0); rd(12'h114);
      step(1'b1, 12'h03C, 32'hDEAD_BEEF, '0, '0); rd(12'h03C);
      for (int c = 0; c < NC; c++) for (int r = 0; r < 5; r++) rd(12'(12'h100 + 32 * c + 4 * r));

      // R10: soft request words
      for (int i = 8; i < 12; i++) begin
         step(1'b1, 12'(4 * i), 32'hFFFF_FFFF, '0, '0);
         rd(12'(4 * i));
      end
      rd(12'h030); rd(12'h014); rd(12'h018);

      // random phase
      for (int n = 0; n < 1500; n++) begin
         step($urandom_range(0, 3) != 0, rand_addr(), $urandom, rand_pulse(), rand_pulse());
         rd(rand_addr());
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule